// File: doc/BRIEF.md
# DMA Channel Source Fetch Controller

This block decides, for one DMA channel whose block length is set by the destination peripheral, when the source side may move data into the channel FIFO. It watches the source and destination handshake requests (single and burst), a byte-level model of the channel FIFO fill, and the bytes still owed to the destination transaction in progress. Each cycle it either starts a source burst, starts a source single, or holds the source off. When the destination flags its final transaction, the block works out how many bytes still have to be fetched. It finishes the source side with single transfers once that remainder falls below one source burst, and raises separate one-cycle done pulses for the source and destination sides.

Configuration arrives on plain inputs: a prefetch-disable bit, a transfer-width code for each side and a burst-length code for each side. Bus protocol, address generation and the FIFO storage are outside the block. The surrounding datapath reports one pulse per completed source beat and one per completed destination beat. The block keeps the FIFO level as a byte counter driven by those pulses. A source burst must not be larger than the FIFO depth in bytes.

Top module: `dma_src_fetch_ctrl`

## Requirements
- R1: A width code c of 0 to 3 means 2^c bytes per beat (3'b010 is 32 bits, 3'b011 is 64 bits), and larger codes count as 8 bytes. A burst code of 0 means 1 item and a code n of 1 or more means 2^(n+1) items, so 3'b001 is 4 items. `fill_bytes` rises by the source width on each accepted `src_beat` and falls by the destination width on each accepted `dst_beat`.
- R2: A source grant appears as a one-cycle pulse on `src_go_burst` or `src_go_single` in the cycle after the decision, never on both together. `src_busy` then stays high until the transaction's item count of `src_beat` pulses has been seen, and no new grant is made while it is high.
- R3: A source transaction is granted only when the free FIFO space is at least its size in bytes, so `fill_bytes` never exceeds the FIFO depth.
- R4: With `prefetch_off` = 0 and before the last destination transaction, a source burst request is granted as a burst whenever a whole burst fits, and otherwise a source single request is granted as a single when one beat fits.
- R5: With `prefetch_off` = 1, a source width code not above the destination width code and no destination transaction active, no source transaction is granted even while the source requests.
- R6: With `prefetch_off` = 1, the source fetches only the bytes the active destination transaction still lacks (its remaining bytes minus the FIFO level). It uses a burst only when that shortfall is at least one source burst, and otherwise a single on either source request.
- R7: After a destination transaction started with `dst_last_req` high, `src_single_zone` is high exactly when the bytes still to fetch are non-zero and strictly below one source burst. Inside the zone either source request gets a single and never a burst. Outside it, with bytes still to fetch, only a source burst request is granted.
- R8: After the last destination transaction has started, once the source is idle and no bytes remain to fetch, `finish[0]` pulses high for one cycle, once per block.
- R9: `finish[1]` pulses high for one cycle in the cycle after the `dst_beat` that completes the last destination transaction.
- R10: While `chan_en` is low or `rst_n` is low, the level, all transaction state, grants and done pulses are cleared. A `src_beat` while no source transaction is active leaves `fill_bytes` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Channel enable; low clears all state |
| prefetch_off | input | 1 | 1 disables read-ahead from the source |
| src_width_code | input | 3 | Source beat width code |
| dst_width_code | input | 3 | Destination beat width code |
| src_burst_code | input | 3 | Source burst length code |
| dst_burst_code | input | 3 | Destination burst length code |
| src_single_req | input | 1 | Source single-transfer request |
| src_burst_req | input | 1 | Source burst-transfer request |
| src_beat | input | 1 | One source beat written into the FIFO |
| dst_single_req | input | 1 | Destination single-transfer request |
| dst_burst_req | input | 1 | Destination burst-transfer request |
| dst_last_req | input | 1 | Marks the requested destination transaction as the last one |
| dst_beat | input | 1 | One destination beat read from the FIFO |
| src_go_burst | output | 1 | Pulse: source burst started |
| src_go_single | output | 1 | Pulse: source single started |
| src_busy | output | 1 | Source transaction in progress |
| dst_busy | output | 1 | Destination transaction in progress |
| fill_bytes | output | LVL_W | FIFO level in bytes |
| src_single_zone | output | 1 | End-of-block single-transfer zone is active |
| finish | output | 2 | Bit 0 source done pulse, bit 1 destination done pulse |

## Verification
The hardest situation to reach is the end of a block where the bytes still to fetch sit exactly at, or just under, one source burst while the source offers only single requests. Any stray destination beat or earlier prefetch moves the remainder away from that boundary. Directed sequences build it from an empty FIFO: they issue a lone last destination burst or single with a 16-byte source burst and hold back source beats. Random blocks then sweep width and burst codes, prefetch mode and request and beat timing against a bench model of the byte counts.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  localparam int BYTES_W   = 12;
  localparam int ITEMS_W   = 9;
  localparam int WCODE_MAX = 3;

  typedef logic [BYTES_W-1:0] bytes_t;
  typedef logic [ITEMS_W-1:0] items_t;
  typedef enum logic [1:0] {GR_NONE, GR_SINGLE, GR_BURST} grant_e;

  // bytes moved by one beat of the given width code
  function automatic bytes_t width_bytes(input logic [2:0] code);
    if (int'(code) > WCODE_MAX) return bytes_t'(1) << WCODE_MAX;
    return bytes_t'(1) << code;
  endfunction

  // items in one burst of the given length code
  function automatic items_t burst_items(input logic [2:0] code);
    if (code == 3'd0) return items_t'(1);
    return items_t'(2) << code;
  endfunction

  function automatic bytes_t txn_bytes(input items_t n, input bytes_t w);
    return bytes_t'(n) * w;
  endfunction

  // bytes still missing when 'have' is held against a need of 'want'
  function automatic bytes_t shortfall(input bytes_t want, input bytes_t have);
    return (want > have) ? (want - have) : '0;
  endfunction
endpackage

// File: rtl/sfc_decode.sv
`timescale 1ns/1ps
module sfc_decode
  import sfc_pkg::*;
(
  input  logic [2:0] src_wc,
  input  logic [2:0] dst_wc,
  input  logic [2:0] src_bc,
  input  logic [2:0] dst_bc,
  output bytes_t     src_w,
  output bytes_t     dst_w,
  output bytes_t     src_burst_b,
  output items_t     src_items,
  output items_t     dst_items
);
  assign src_w       = width_bytes(src_wc);
  assign dst_w       = width_bytes(dst_wc);
  assign src_items   = burst_items(src_bc);
  assign dst_items   = burst_items(dst_bc);
  assign src_burst_b = txn_bytes(src_items, src_w);
endmodule

// File: rtl/sfc_fill_track.sv
`timescale 1ns/1ps
module sfc_fill_track
  import sfc_pkg::*;
#(
  parameter int FIFO_BYTES = 32,
  parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             add_en,
  input  logic             sub_en,
  input  bytes_t           add_b,
  input  bytes_t           sub_b,
  output logic [LVL_W-1:0] level,
  output bytes_t           level_b,
  output bytes_t           free_b
);
  typedef logic [LVL_W-1:0] lvl_t;

  lvl_t   level_q;
  bytes_t level_nxt;

  assign level_b = bytes_t'(level_q);
  assign free_b  = bytes_t'(FIFO_BYTES) - level_b;
  assign level   = level_q;

  always_comb begin
    level_nxt = level_b + (add_en ? add_b : '0) - (sub_en ? sub_b : '0);
  end

  always_ff @(posedge clk) begin
    if (clr) level_q <= '0;
    else     level_q <= lvl_t'(level_nxt);
  end
endmodule

// File: rtl/sfc_dst_track.sv
`timescale 1ns/1ps
module sfc_dst_track
  import sfc_pkg::*;
(
  input  logic   clk,
  input  logic   clr,
  input  logic   single_req,
  input  logic   burst_req,
  input  logic   last_req,
  input  logic   beat,
  input  bytes_t dst_w,
  input  items_t dst_items,
  output logic   busy,
  output bytes_t rem,
  output logic   last_seen,
  output logic   beat_ok,
  output logic   done_pulse
);
  logic   busy_q, fin_q, last_q, tail_q, pulse_q;
  bytes_t rem_q;
  logic   start_w, ends_w;

  assign start_w = !busy_q && !fin_q && (single_req || burst_req);
  assign beat_ok = busy_q && beat;
  assign ends_w  = beat_ok && (rem_q <= dst_w);

  always_ff @(posedge clk) begin
    if (clr) begin
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      last_q  <= 1'b0;
      tail_q  <= 1'b0;
      pulse_q <= 1'b0;
      rem_q   <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (start_w) begin
        busy_q <= 1'b1;
        rem_q  <= txn_bytes(burst_req ? dst_items : items_t'(1), dst_w);
        tail_q <= last_req;
        if (last_req) last_q <= 1'b1;
      end else if (beat_ok) begin
        rem_q <= ends_w ? '0 : (rem_q - dst_w);
        if (ends_w) begin
          busy_q <= 1'b0;
          if (tail_q) begin
            fin_q   <= 1'b1;
            pulse_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy       = busy_q;
  assign rem        = rem_q;
  assign last_seen  = last_q;
  assign done_pulse = pulse_q;
endmodule

// File: rtl/sfc_src_arb.sv
`timescale 1ns/1ps
module sfc_src_arb
  import sfc_pkg::*;
(
  input  logic   clk,
  input  logic   clr,
  input  logic   prefetch_off,
  input  logic   single_req,
  input  logic   burst_req,
  input  logic   beat,
  input  bytes_t fill_b,
  input  bytes_t free_b,
  input  logic   dst_busy,
  input  bytes_t dst_rem,
  input  logic   last_seen,
  input  bytes_t src_w,
  input  bytes_t src_burst_b,
  input  items_t src_items,
  output logic   go_burst,
  output logic   go_single,
  output logic   busy,
  output logic   beat_ok,
  output logic   single_zone,
  output logic   done_pulse
);
  logic   busy_q, fin_q, pulse_q, gb_q, gs_q;
  items_t beats_q;
  bytes_t fetch_left, need;
  logic   idle, burst_fits, single_fits, finish_now;
  grant_e grant;

  assign fetch_left  = shortfall(dst_rem, fill_b);
  assign need        = dst_busy ? fetch_left : '0;
  assign single_zone = last_seen && (fetch_left != '0) && (fetch_left < src_burst_b);
  assign idle        = !busy_q && !fin_q;
  assign burst_fits  = free_b >= src_burst_b;
  assign single_fits = free_b >= src_w;
  assign finish_now  = idle && last_seen && (fetch_left == '0);
  assign beat_ok     = busy_q && beat;

  always_comb begin
    grant = GR_NONE;
    if (idle) begin
      if (last_seen) begin
        if (single_zone) begin
          if ((single_req || burst_req) && single_fits) grant = GR_SINGLE;
        end else if (fetch_left != '0 && burst_req && burst_fits) begin
          grant = GR_BURST;
        end
      end else if (!prefetch_off) begin
        if (burst_req && burst_fits)        grant = GR_BURST;
        else if (single_req && single_fits) grant = GR_SINGLE;
      end else begin
        if (burst_req && need >= src_burst_b && burst_fits)
          grant = GR_BURST;
        else if ((single_req || burst_req) && need != '0 && single_fits)
          grant = GR_SINGLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      pulse_q <= 1'b0;
      gb_q    <= 1'b0;
      gs_q    <= 1'b0;
      beats_q <= '0;
    end else begin
      gb_q    <= (grant == GR_BURST);
      gs_q    <= (grant == GR_SINGLE);
      pulse_q <= finish_now;
      if (finish_now) fin_q <= 1'b1;
      if (grant != GR_NONE) begin
        busy_q  <= 1'b1;
        beats_q <= (grant == GR_BURST) ? src_items : items_t'(1);
      end else if (beat_ok) begin
        beats_q <= beats_q - items_t'(1);
        if (beats_q == items_t'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign go_burst   = gb_q;
  assign go_single  = gs_q;
  assign busy       = busy_q;
  assign done_pulse = pulse_q;
endmodule

// File: rtl/dma_src_fetch_ctrl.sv
`timescale 1ns/1ps
module dma_src_fetch_ctrl
  import sfc_pkg::*;
#(
  parameter  int FIFO_BYTES = 32,
  localparam int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             prefetch_off,
  input  logic [2:0]       src_width_code,
  input  logic [2:0]       dst_width_code,
  input  logic [2:0]       src_burst_code,
  input  logic [2:0]       dst_burst_code,
  input  logic             src_single_req,
  input  logic             src_burst_req,
  input  logic             src_beat,
  input  logic             dst_single_req,
  input  logic             dst_burst_req,
  input  logic             dst_last_req,
  input  logic             dst_beat,
  output logic             src_go_burst,
  output logic             src_go_single,
  output logic             src_busy,
  output logic             dst_busy,
  output logic [LVL_W-1:0] fill_bytes,
  output logic             src_single_zone,
  output logic [1:0]       finish
);
  logic   clr_w;
  bytes_t src_w, dst_w, src_burst_b;
  items_t src_items, dst_items;
  bytes_t level_b, free_b, dst_rem_w;
  logic   src_beat_ok_w, dst_beat_ok_w;
  logic   last_seen_w, src_done_w, dst_done_w;

  assign clr_w = !rst_n || !chan_en;

  sfc_decode u_decode (
    .src_wc(src_width_code), .dst_wc(dst_width_code),
    .src_bc(src_burst_code), .dst_bc(dst_burst_code),
    .src_w(src_w), .dst_w(dst_w), .src_burst_b(src_burst_b),
    .src_items(src_items), .dst_items(dst_items)
  );

  sfc_fill_track #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_fill (
    .clk(clk), .clr(clr_w),
    .add_en(src_beat_ok_w), .sub_en(dst_beat_ok_w),
    .add_b(src_w), .sub_b(dst_w),
    .level(fill_bytes), .level_b(level_b), .free_b(free_b)
  );

  sfc_dst_track u_dst (
    .clk(clk), .clr(clr_w),
    .single_req(dst_single_req), .burst_req(dst_burst_req),
    .last_req(dst_last_req), .beat(dst_beat),
    .dst_w(dst_w), .dst_items(dst_items),
    .busy(dst_busy), .rem(dst_rem_w), .last_seen(last_seen_w),
    .beat_ok(dst_beat_ok_w), .done_pulse(dst_done_w)
  );

  sfc_src_arb u_arb (
    .clk(clk), .clr(clr_w), .prefetch_off(prefetch_off),
    .single_req(src_single_req), .burst_req(src_burst_req), .beat(src_beat),
    .fill_b(level_b), .free_b(free_b),
    .dst_busy(dst_busy), .dst_rem(dst_rem_w), .last_seen(last_seen_w),
    .src_w(src_w), .src_burst_b(src_burst_b), .src_items(src_items),
    .go_burst(src_go_burst), .go_single(src_go_single), .busy(src_busy),
    .beat_ok(src_beat_ok_w), .single_zone(src_single_zone),
    .done_pulse(src_done_w)
  );

  assign finish = {dst_done_w, src_done_w};
endmodule

// File: rtl/sfc_checker.sv
`timescale 1ns/1ps
module sfc_checker #(
  parameter int FIFO_BYTES = 32,
  parameter int LVL_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             prefetch_off,
  input logic [2:0]       src_width_code,
  input logic [2:0]       dst_width_code,
  input logic             src_go_burst,
  input logic             src_go_single,
  input logic             src_busy,
  input logic             dst_busy,
  input logic [LVL_W-1:0] fill_bytes,
  input logic             src_single_zone,
  input logic [1:0]       finish,
  input logic             last_seen
);
  p_grant_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_go_burst && src_go_single));

  p_busy_with_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_go_burst || src_go_single) |-> src_busy);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_bytes) <= FIFO_BYTES);

  p_idle_no_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && prefetch_off && (src_width_code <= dst_width_code) &&
     !dst_busy && !last_seen && !src_busy)
    |=> !(src_go_burst || src_go_single));

  p_zone_no_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    src_single_zone |=> !src_go_burst);

  p_src_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finish[0] |=> !finish[0]);

  p_src_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finish[0] |-> last_seen);

  p_dst_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish[1] |=> !finish[1]);

  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (fill_bytes == '0 && finish == 2'b00 && !src_go_burst && !src_go_single));
endmodule

bind dma_src_fetch_ctrl sfc_checker #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_sfc_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .prefetch_off(prefetch_off),
  .src_width_code(src_width_code), .dst_width_code(dst_width_code),
  .src_go_burst(src_go_burst), .src_go_single(src_go_single),
  .src_busy(src_busy), .dst_busy(dst_busy), .fill_bytes(fill_bytes),
  .src_single_zone(src_single_zone), .finish(finish), .last_seen(last_seen_w)
);

// File: tb/dma_src_fetch_ctrl_bench.sv
`timescale 1ns/1ps
module dma_src_fetch_ctrl_bench;
  localparam int FIFO_BYTES = 32;
  localparam int LVL_W      = $clog2(FIFO_BYTES + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, chan_en, prefetch_off;
  logic [2:0] swc, dwc, sbc, dbc;
  logic ssr, sbr, sb, dsr, dbr, dl, db;
  logic src_go_burst, src_go_single, src_busy, dst_busy, src_single_zone;
  logic [LVL_W-1:0] fill_bytes;
  logic [1:0] finish;

  dma_src_fetch_ctrl #(.FIFO_BYTES(FIFO_BYTES)) u_dma_src_fetch_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .prefetch_off(prefetch_off),
    .src_width_code(swc), .dst_width_code(dwc),
    .src_burst_code(sbc), .dst_burst_code(dbc),
    .src_single_req(ssr), .src_burst_req(sbr), .src_beat(sb),
    .dst_single_req(dsr), .dst_burst_req(dbr), .dst_last_req(dl), .dst_beat(db),
    .src_go_burst(src_go_burst), .src_go_single(src_go_single),
    .src_busy(src_busy), .dst_busy(dst_busy), .fill_bytes(fill_bytes),
    .src_single_zone(src_single_zone), .finish(finish)
  );

  int total = 0, bad = 0;
  bit done_flag = 0;

  // bench model state, in bytes and items
  int m_fifo, m_sact, m_sbeats, m_sfin, m_dact, m_drem, m_dtail, m_dfin, m_last, m_dstarts;
  int e_gb, e_gs, e_f0, e_f1, e_zone, r5_case;
  string g_tag;

  function automatic int f_w(input logic [2:0] c);
    return (c > 3'd3) ? 8 : (1 << c);
  endfunction
  function automatic int f_items(input logic [2:0] c);
    return (c == 3'd0) ? 1 : (2 << c);
  endfunction
  function automatic int f_gap(input int want, input int have);
    return (want > have) ? want - have : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_fifo = 0; m_sact = 0; m_sbeats = 0; m_sfin = 0; m_dact = 0;
    m_drem = 0; m_dtail = 0; m_dfin = 0; m_last = 0; m_dstarts = 0;
  endtask

  // one clock: model the edge from the driven inputs, then compare after it
  task automatic step();
    int sw, dw, sbb, free_b, fl, need, nf;
    sw = f_w(swc); dw = f_w(dwc); sbb = f_items(sbc) * sw;
    e_gb = 0; e_gs = 0; e_f0 = 0; e_f1 = 0; r5_case = 0;
    g_tag = m_last ? "R7" : (prefetch_off ? "R6" : "R4");
    if (!rst_n || !chan_en) begin
      model_clear();
      g_tag = "R10";
    end else begin
      free_b = FIFO_BYTES - m_fifo;
      fl = f_gap(m_drem, m_fifo);
      need = m_dact ? fl : 0;
      r5_case = prefetch_off && (swc <= dwc) && !m_dact && !m_last && !m_sact;
      if (!m_sact && !m_sfin) begin
        if (m_last) begin
          if (fl == 0) e_f0 = 1;
          else if (fl < sbb) begin
            if ((ssr || sbr) && free_b >= sw) e_gs = 1;
          end else if (sbr && free_b >= sbb) e_gb = 1;
        end else if (!prefetch_off) begin
          if (sbr && free_b >= sbb) e_gb = 1;
          else if (ssr && free_b >= sw) e_gs = 1;
        end else begin
          if (sbr && need >= sbb && free_b >= sbb) e_gb = 1;
          else if ((ssr || sbr) && need > 0 && free_b >= sw) e_gs = 1;
        end
      end
      nf = m_fifo;
      if (m_sact && sb) begin
        nf += sw;
        m_sbeats--;
        if (m_sbeats == 0) m_sact = 0;
      end
      if (m_dact) begin
        if (db) begin
          nf -= dw;
          if (m_drem <= dw) begin
            m_drem = 0; m_dact = 0;
            if (m_dtail) begin m_dfin = 1; e_f1 = 1; end
          end else m_drem -= dw;
        end
      end else if (!m_dfin && (dsr || dbr)) begin
        m_dact = 1;
        m_drem = (dbr ? f_items(dbc) : 1) * dw;
        m_dtail = dl;
        if (dl) m_last = 1;
        m_dstarts++;
      end
      if (e_gb) begin m_sact = 1; m_sbeats = f_items(sbc); end
      if (e_gs) begin m_sact = 1; m_sbeats = 1; end
      if (e_f0) m_sfin = 1;
      m_fifo = nf;
    end
    fl = f_gap(m_drem, m_fifo);
    e_zone = m_last && fl > 0 && fl < sbb;
    @(negedge clk);
    chk(int'(fill_bytes) == m_fifo, "R1 fill level", int'(fill_bytes), m_fifo);
    chk(src_go_burst == e_gb[0], {g_tag, " burst grant"}, src_go_burst, e_gb);
    chk(src_go_single == e_gs[0], {g_tag, " single grant"}, src_go_single, e_gs);
    chk(!(src_go_burst && src_go_single), "R2 both grants", 1, 0);
    chk(src_busy == m_sact[0], "R2 src busy", src_busy, m_sact);
    chk(int'(fill_bytes) <= FIFO_BYTES, "R3 overflow", int'(fill_bytes), FIFO_BYTES);
    chk(src_single_zone == e_zone[0], "R7 zone", src_single_zone, e_zone);
    chk(finish[0] == e_f0[0], "R8 src done", finish[0], e_f0);
    chk(finish[1] == e_f1[0], "R9 dst done", finish[1], e_f1);
    if (r5_case) chk(!(src_go_burst || src_go_single), "R5 idle fetch", 1, 0);
    if (!chan_en) chk(fill_bytes == '0 && finish == 2'b00, "R10 cleared", int'(fill_bytes), 0);
  endtask

  task automatic quiet();
    ssr = 0; sbr = 0; sb = 0; dsr = 0; dbr = 0; dl = 0; db = 0;
  endtask

  task automatic restart();
    quiet();
    chan_en = 0; step(); step();
    chan_en = 1;
  endtask

  task automatic drain(input int n, output int f0s, output int f1s);
    f0s = 0; f1s = 0;
    for (int i = 0; i < n; i++) begin
      sb = m_sact[0];
      db = m_dact[0] && (m_fifo >= f_w(dwc));
      step();
      f0s += finish[0]; f1s += finish[1];
    end
    quiet();
  endtask

  task automatic run_random_block();
    int nd, cyc, f0s, f1s;
    do begin
      swc = 3'($urandom % 4); sbc = 3'($urandom % 3);
    end while (f_items(sbc) * f_w(swc) > FIFO_BYTES);
    dwc = 3'($urandom % 4); dbc = 3'($urandom % 3);
    prefetch_off = 1'($urandom % 2);
    restart();
    nd = $urandom % 5;
    f0s = 0; f1s = 0;
    for (cyc = 0; cyc < 4000; cyc++) begin
      ssr = 1'($urandom % 2);
      sbr = 1'($urandom % 2);
      sb  = m_sact[0] && ($urandom % 4 != 0);
      db  = m_dact[0] && (m_fifo >= f_w(dwc)) && ($urandom % 3 != 0);
      dsr = ($urandom % 5 == 0);
      dbr = ($urandom % 4 == 0);
      dl  = (m_dstarts == nd);
      step();
      f0s += finish[0]; f1s += finish[1];
      if (m_sfin && m_dfin) break;
    end
    chk(cyc < 4000, "R9 block ends (watchdog)", cyc, 4000);
    quiet(); step();
    f0s += finish[0]; f1s += finish[1];
    chk(f0s == 1, "R8 one src done per block", f0s, 1);
    chk(f1s == 1, "R9 one dst done per block", f1s, 1);
  endtask

  initial begin
    int f0s, f1s, keep;
    void'($urandom(32'h5eed_0042));
    rst_n = 0; chan_en = 0; prefetch_off = 0;
    swc = 3'd2; dwc = 3'd2; sbc = 3'd1; dbc = 3'd1;
    quiet();
    repeat (3) @(negedge clk);
    model_clear();
    chk(fill_bytes == '0 && finish == 2'b00 && !src_busy && !dst_busy, "R10 reset state", int'(fill_bytes), 0);
    rst_n = 1;
    restart();

    // R7: last burst needs exactly one source burst, no single zone
    dbr = 1; dl = 1; step(); quiet();
    chk(src_single_zone == 1'b0, "R7 remainder equals burst", src_single_zone, 0);
    ssr = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(src_go_single == 1'b0, "R7 single refused outside zone", src_go_single, 0);
    end
    sbr = 1; step(); quiet();
    chk(src_go_burst == 1'b1, "R7 burst granted at boundary", src_go_burst, 1);
    drain(16, f0s, f1s);
    chk(f0s == 1, "R8 src done once", f0s, 1);
    chk(f1s == 1, "R9 dst done once", f1s, 1);

    // R7: last single leaves 4 bytes, below a 16-byte burst
    restart();
    dsr = 1; dl = 1; step(); quiet();
    chk(src_single_zone == 1'b1, "R7 zone entered", src_single_zone, 1);
    sbr = 1; step(); quiet();
    chk(src_go_single == 1'b1, "R7 single on burst request in zone", src_go_single, 1);
    drain(10, f0s, f1s);
    chk(f0s == 1 && f1s == 1, "R8 R9 done after single", f0s + f1s, 2);

    // R5 and R6: prefetch off, 4-byte source into 8-byte destination
    prefetch_off = 1; swc = 3'd2; dwc = 3'd3; sbc = 3'd1; dbc = 3'd0;
    restart();
    ssr = 1; sbr = 1;
    for (int i = 0; i < 8; i++) begin
      step();
      chk(!(src_go_burst || src_go_single) && fill_bytes == '0, "R5 no fetch without destination", int'(fill_bytes), 0);
    end
    dbr = 1; step(); dbr = 0;
    step();
    chk(src_go_single == 1'b1, "R6 single for short need", src_go_single, 1);
    sb = 1; step(); sb = 0;
    step();
    chk(src_go_single == 1'b1, "R6 second single fills need", src_go_single, 1);
    sb = 1; step(); sb = 0;
    step();
    chk(!(src_go_burst || src_go_single) && int'(fill_bytes) == 8, "R6 stops at need", int'(fill_bytes), 8);
    quiet();

    // R10: stray source beat while idle
    keep = int'(fill_bytes);
    sb = 1; step(); sb = 0;
    chk(int'(fill_bytes) == keep, "R10 idle beat ignored", int'(fill_bytes), keep);

    // R3 and R4: prefetch on, fill to the top with no destination
    prefetch_off = 0; swc = 3'd2; sbc = 3'd1;
    restart();
    for (int i = 0; i < 20; i++) begin
      sbr = 1; ssr = 1; sb = m_sact[0];
      step();
    end
    quiet();
    chk(int'(fill_bytes) == FIFO_BYTES, "R3 R4 prefetch fills FIFO", int'(fill_bytes), FIFO_BYTES);
    chk(!src_busy, "R3 no grant when full", src_busy, 0);

    for (int b = 0; b < 40; b++) run_random_block();

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule